// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one capture channel that sits beside a free-running timer counter. It picks a trigger source from one of four choices: two external pins, a constant low or a constant high. It watches that source for the chosen kind of transition. When the transition arrives, it copies the present counter value into a capture register. Each capture raises a pending flag. If a new capture lands while that flag is still set, an overflow flag records that a value was lost.

Software drives the channel through a single control word. The word holds the capture enable, the trigger kind, the source choice, a synchronise option and the interrupt enable, and it can write both flags. A read returns the same word plus the present level of the chosen source. Flipping the source between the constant low and the constant high produces a transition that the edge logic sees, so software can take a snapshot of the counter at any moment. The synchronise option routes the source through a two-flop synchroniser before edge detection. Without it, the source is compared directly against its value from the previous clock.

Top module: `cap_channel`

## Requirements
- R1: After reset, the control word, both flags, the capture register and `irq` are all 0.
- R2: While control bit 0 (capture enable) is 0, no transition of any source changes the capture register or sets the pending flag.
- R3: Control bits 2:1 choose the trigger: 00 none, 01 rising, 10 falling, 11 both. A transition that the chosen trigger does not include causes no capture.
- R4: Control bits 4:3 choose the source: 00 pin A, 01 pin B, 10 constant 0, 11 constant 1. A write that moves the source from 10 to 11 with a rising trigger captures the counter value present one clock after the edge that accepts the write.
- R5: A capture loads `cnt_in` into `cap_value` and sets the pending flag (control bit 7). With control bit 5 at 0, a pin level that is present at a rising clock edge is captured at that same edge, along with the counter value sampled at that edge.
- R6: With control bit 5 at 1, the same pin change is captured two clock edges later, along with the counter value sampled at that later edge.
- R7: `irq` is 1 exactly when the pending flag and control bit 6 (interrupt enable) are both 1.
- R8: The overflow flag (control bit 8) is set by a capture that occurs while the pending flag is 1. A capture while the pending flag is 0 leaves it at 0.
- R9: Software writes replace the pending and overflow flags. Once set, the overflow flag stays at 1 until a write carries 0 in bit 8.
- R10: Read bit 9 of `ctl_rdata` shows the present level of the selected source, unsynchronised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 10 | Control word write data (bit 9 ignored) |
| ctl_rdata | output | 10 | Control word readback with source level in bit 9 |
| cnt_in | input | 16 | Current timer counter value |
| in_a | input | 1 | External capture pin A |
| in_b | input | 1 | External capture pin B |
| cap_value | output | 16 | Captured counter value |
| cap_flag | output | 1 | Pending capture flag |
| cap_ovf | output | 1 | Missed capture flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a capture that software triggers with no pin activity at all. To get there, the bench writes the constant-low source, then writes the constant-high source. It expects the counter value from one clock after the edge that accepts the second write.

Overflow likewise needs two captures with no flag clear between them. The bench uses the both-edges trigger on pin B, so a single pulse supplies both captures.

The synchronised path is exercised by sampling the flag on each of the three clocks after a pin change. This pins down the exact two-cycle extra latency.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        TRG_OFF  = 2'b00,
        TRG_RISE = 2'b01,
        TRG_FALL = 2'b10,
        TRG_BOTH = 2'b11
    } trig_e;

    typedef enum logic [1:0] {
        SRC_PIN_A = 2'b00,
        SRC_PIN_B = 2'b01,
        SRC_LOW   = 2'b10,
        SRC_HIGH  = 2'b11
    } src_e;

    // Packed LSB-last: cap_en is bit 0, ovf is bit 8
    typedef struct packed {
        logic  ovf;
        logic  flag;
        logic  irq_en;
        logic  sync_en;
        src_e  src;
        trig_e trig;
        logic  cap_en;
    } ctl_t;

    localparam int CTL_BITS = $bits(ctl_t);
    localparam int CTL_W    = CTL_BITS + 1;   // plus read-only level bit
    localparam int OVF_BIT  = CTL_BITS - 1;

endpackage

// File: rtl/cap_src_sel.sv
module cap_src_sel
    import cap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_a,
    input  logic in_b,
    input  src_e src,
    input  logic sync_en,
    output logic raw_o,
    output logic path_o
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_d, sync_q;
    logic          raw;

    always_comb begin
        unique case (src)
            SRC_PIN_A: raw = in_a;
            SRC_PIN_B: raw = in_b;
            SRC_LOW:   raw = 1'b0;
            default:   raw = 1'b1;
        endcase
    end

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_comb sync_d[i] = raw;
        end else begin : g_next
            always_comb sync_d[i] = sync_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign raw_o  = raw;
    assign path_o = sync_en ? sync_q[LAST] : raw;

endmodule

// File: rtl/cap_edge_det.sv
module cap_edge_det
    import cap_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sig,
    input  logic  arm,
    input  trig_e trig,
    output logic  hit
);

    typedef struct packed {
        logic prev;
    } ed_t;

    ed_t  ed_d, ed_q;
    logic rise, fall;

    always_comb begin
        ed_d      = ed_q;
        ed_d.prev = sig;
        rise      = sig & ~ed_q.prev;
        fall      = ~sig & ed_q.prev;
        hit       = arm & ((trig[0] & rise) | (trig[1] & fall));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ed_q <= '0;
        else        ed_q <= ed_d;
    end

endmodule

// File: rtl/cap_channel.sv
module cap_channel
    import cap_pkg::*;
#(
    parameter int TW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic [TW-1:0]    cnt_in,
    input  logic             in_a,
    input  logic             in_b,
    output logic [TW-1:0]    cap_value,
    output logic             cap_flag,
    output logic             cap_ovf,
    output logic             irq
);

    typedef struct packed {
        ctl_t          ctl;
        logic [TW-1:0] cap;
    } st_t;

    st_t  st_d, st_q;
    logic raw_lvl, path_sig, hit;
    logic wdata_unused;

    assign wdata_unused = ctl_wdata[CTL_W-1];

    cap_src_sel #(.SYNC_STAGES(SYNC_STAGES)) i_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_a    (in_a),
        .in_b    (in_b),
        .src     (st_q.ctl.src),
        .sync_en (st_q.ctl.sync_en),
        .raw_o   (raw_lvl),
        .path_o  (path_sig)
    );

    cap_edge_det i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (path_sig),
        .arm   (st_q.ctl.cap_en),
        .trig  (st_q.ctl.trig),
        .hit   (hit)
    );

    always_comb begin
        st_d = st_q;
        if (ctl_we) begin
            st_d.ctl = ctl_t'(ctl_wdata[CTL_BITS-1:0]);
        end
        if (hit) begin
            st_d.cap      = cnt_in;
            st_d.ctl.flag = 1'b1;
            if (st_q.ctl.flag) begin
                st_d.ctl.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_rdata = {raw_lvl, st_q.ctl};
    assign cap_value = st_q.cap;
    assign cap_flag  = st_q.ctl.flag;
    assign cap_ovf   = st_q.ctl.ovf;
    assign irq       = st_q.ctl.flag & st_q.ctl.irq_en;

    assert_capture_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> cap_value == $past(cnt_in));

    assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> cap_flag);

    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctl.cap_en |=> $stable(cap_value));

    assert_ovf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cap_flag) |=> cap_ovf);

    assert_ovf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ovf && !(ctl_we && !ctl_wdata[OVF_BIT])) |=> cap_ovf);

endmodule

// File: tb/test_cap_channel.sv
module test_cap_channel;
    import cap_pkg::*;

    localparam int TW = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_we;
    logic [CTL_W-1:0] ctl_wdata, ctl_rdata;
    logic [TW-1:0]    cnt_in = 16'h1000;
    logic             in_a, in_b;
    logic [TW-1:0]    cap_value;
    logic             cap_flag, cap_ovf, irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [TW-1:0] exp_q[$];
    logic [TW-1:0] last_cap = '0;

    always #5 clk = ~clk;
    always @(posedge clk) cnt_in <= cnt_in + 1'b1;

    cap_channel i_cap_channel (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .cnt_in(cnt_in), .in_a(in_a), .in_b(in_b),
        .cap_value(cap_value), .cap_flag(cap_flag), .cap_ovf(cap_ovf), .irq(irq)
    );

    function automatic logic [CTL_W-1:0] cw(bit cap, bit [1:0] trg, bit [1:0] src,
                                            bit sync, bit ie, bit flg, bit ovf);
        return {1'b0, ovf, flg, ie, sync, src, trg, cap};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // lat < 0: no capture expected; otherwise expect cnt_in + lat
    task automatic wr(logic [CTL_W-1:0] v, int lat);
        @(negedge clk);
        if (lat >= 0) exp_q.push_back(cnt_in + TW'(lat));
        ctl_we    = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_we    = 1'b0;
    endtask

    task automatic set_a(logic v, int lat);
        @(negedge clk);
        if (lat >= 0) exp_q.push_back(cnt_in + TW'(lat));
        in_a = v;
    endtask

    task automatic set_b(logic v, int lat);
        @(negedge clk);
        if (lat >= 0) exp_q.push_back(cnt_in + TW'(lat));
        in_b = v;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Scoreboard monitor: every change of the capture register pops one item
    always @(negedge clk) begin
        if (rst_n && cap_value !== last_cap) begin
            last_cap = cap_value;
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R5 unexpected capture actual=%0h expected=none", cap_value);
            end else begin
                chk("R5 captured counter value", 32'(cap_value), 32'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin
        ctl_we = 1'b0; ctl_wdata = '0; in_a = 1'b0; in_b = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 control readback", 32'(ctl_rdata), 0);
        chk("R1 capture register", 32'(cap_value), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 flags", 32'({cap_flag, cap_ovf}), 0);

        // R2: edges with capture disabled
        wr(cw(0, 2'b11, 2'b00, 0, 0, 0, 0), -1);
        set_a(1, -1); idle(3); set_a(0, -1); idle(3);
        chk("R2 flag stays clear", 32'(cap_flag), 0);
        chk("R2 capture register unchanged", 32'(cap_value), 0);

        // R3/R5: rising, asynchronous path, pin A
        wr(cw(1, 2'b01, 2'b00, 0, 0, 0, 0), -1);
        idle(2);
        set_a(1, 0); idle(3);
        chk("R5 flag set on capture", 32'(cap_flag), 1);
        chk("R10 level of pin A", 32'(ctl_rdata[9]), 1);
        wr(cw(1, 2'b01, 2'b00, 0, 0, 0, 0), -1);
        chk("R9 flag cleared by write", 32'(cap_flag), 0);
        set_a(0, -1); idle(3);
        chk("R3 falling ignored in rising mode", 32'(cap_flag), 0);

        // R3: falling mode
        wr(cw(1, 2'b10, 2'b00, 0, 0, 0, 0), -1);
        set_a(1, -1); idle(3);
        chk("R3 rising ignored in falling mode", 32'(cap_flag), 0);
        set_a(0, 0); idle(3);
        chk("R3 falling captured", 32'(cap_flag), 1);
        chk("R8 no overflow from single capture", 32'(cap_ovf), 0);

        // R3/R8: both edges on pin B, second capture overflows
        wr(cw(1, 2'b11, 2'b01, 0, 0, 0, 0), -1);
        set_b(1, 0); idle(3);
        chk("R8 first capture no overflow", 32'(cap_ovf), 0);
        set_b(0, 0); idle(3);
        chk("R8 overflow on unserviced capture", 32'(cap_ovf), 1);
        wr(cw(1, 2'b11, 2'b01, 0, 0, 0, 1), -1);
        chk("R9 overflow kept by write of 1", 32'(cap_ovf), 1);
        chk("R9 flag cleared alongside", 32'(cap_flag), 0);
        idle(2);
        chk("R9 overflow held without write", 32'(cap_ovf), 1);
        wr(cw(1, 2'b11, 2'b01, 0, 0, 0, 0), -1);
        chk("R9 overflow cleared by write of 0", 32'(cap_ovf), 0);

        // R4: software capture via constant sources
        wr(cw(1, 2'b01, 2'b10, 0, 0, 0, 0), -1);
        idle(2);
        chk("R4 constant low gives no capture", 32'(cap_flag), 0);
        chk("R10 level of constant low", 32'(ctl_rdata[9]), 0);
        wr(cw(1, 2'b01, 2'b11, 0, 0, 0, 0), 1);
        idle(3);
        chk("R4 software capture flag", 32'(cap_flag), 1);
        chk("R10 level of constant high", 32'(ctl_rdata[9]), 1);
        wr(cw(1, 2'b01, 2'b10, 0, 0, 0, 0), -1);
        idle(3);
        chk("R4 high to low gives no rising capture", 32'(cap_flag), 0);

        // R6: synchronised path, two extra edges
        wr(cw(1, 2'b01, 2'b00, 1, 0, 0, 0), -1);
        idle(4);
        set_a(1, 2);
        idle(1);
        chk("R6 not captured after one edge", 32'(cap_flag), 0);
        idle(1);
        chk("R6 not captured after two edges", 32'(cap_flag), 0);
        idle(1);
        chk("R6 captured after three edges", 32'(cap_flag), 1);

        // R7: interrupt gating
        wr(cw(1, 2'b01, 2'b00, 1, 0, 1, 0), -1);
        chk("R7 irq off when disabled", 32'(irq), 0);
        wr(cw(1, 2'b01, 2'b00, 1, 1, 1, 0), -1);
        chk("R7 irq on with flag and enable", 32'(irq), 1);
        wr(cw(1, 2'b01, 2'b00, 1, 1, 0, 0), -1);
        chk("R7 irq off with flag clear", 32'(irq), 0);
        set_a(0, -1); idle(4);
        set_a(1, 2); idle(4);
        chk("R7 irq raised by hardware capture", 32'(irq), 1);

        idle(2);
        chk("R5 all expected captures seen", exp_q.size(), 0);
        done = 1;
        report();
    end

endmodule